// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Front End

This block is the digital side of a two-channel 16-bit voltage DAC. A host writes 24-bit frames over a serial slave port: a clock, an active-low frame select, a data input, and a data output that can be disabled. The block decodes each frame and keeps two registers per channel. The input register holds a staged code. The DAC register holds the code the converter shows. A separate load strobe moves staged codes into the DAC registers, so both channels can change together. If the strobe is tied low, each write takes effect as soon as its frame ends.

All port inputs are asynchronous to the system clock. Each one is synchronised and edge-detected before use, so the serial clock must be several times slower than the system clock. A falling edge on the clear input, or the system reset, loads zero scale or midscale into both channels, depending on the reset-select strap. While the clear input is held low, load strobes have no effect. The data output has two uses. In chained mode it returns the previous frame unchanged. After a read request it returns one register's contents.

Top module: `dual_dac_serial_regs`

## Requirements
- R1: A frame is the 24 bits sampled on serial-clock falling edges while `sync_n` is low, MSB first. The fields are opcode [23:20], channel select [19:16] (bit 16 = channel A, bit 17 = channel B, both bits may be set) and code [15:0]. Opcode 3 writes the code into the input register and the DAC register of every selected channel.
- R2: A frame changes no register if `sync_n` rises before the 24th falling edge. The same holds if select bits 19:18 are not both zero.
- R3: Falling edges after the 24th in one frame are ignored. The frame keeps its first 24 bits.
- R4: Opcode 1 writes only the input register and marks it as holding new data. A falling edge on `ldac_n` copies each marked input register into its DAC register. Unmarked channels keep their DAC code.
- R5: When both select bits are set, one write and one `ldac_n` pulse update both channels together.
- R6: If `ldac_n` is low when an opcode 1 frame ends, the DAC register of each selected channel takes the new code at once.
- R7: Opcode 2 copies the input register of each selected channel into its DAC register.
- R8: A falling edge on `clr_n` loads the input and DAC registers of both channels with 0x0000 when `rst_sel` is 0, or with 0x8000 when `rst_sel` is 1.
- R9: An `ldac_n` falling edge while `clr_n` is low is ignored. Marked data stays marked and is copied by the first strobe after `clr_n` is released.
- R10: After `rst`, both DAC codes equal the `rst_sel`-selected value and all other state is cleared.
- R11: Opcode 9 arms a readback. Channel A is read if bit 16 is set, otherwise channel B. During the next frame, `sdo` shifts out {8'h00, that channel's input register}, MSB first and valid at each falling edge, with `sdo_en` high.
- R12: Opcode 15 with code bit 0 = 1 turns on chained mode; with code bit 0 = 0 it turns chained mode off. In chained mode, each frame shifts out on `sdo` the full 24-bit word received in the previous completed frame.
- R13: Opcode 4 stores code bits [1:0] as the power-down state bits (bit 0 = channel A, bit 1 = channel B).
- R14: `sdo_en` is low outside frames. Within a frame it is high only when chained mode is on or a readback is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_sel | input | 1 | Reset value strap: 0 = zero scale, 1 = midscale |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low DAC load strobe |
| clr_n | input | 1 | Clear input, acts on its falling edge |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Drive enable for sdo (low = high impedance) |
| code_a | output | 16 | DAC register of channel A |
| code_b | output | 16 | DAC register of channel B |
| pd_state | output | 2 | Stored power-down bits, one per channel |

## Verification
The hardest state to reach is a write that is still pending while the clear input is held low. A plain clear would erase the pending data, so the order matters. The bench first drops `clr_n` so the reset happens. While `clr_n` stays low, it sends an opcode 1 frame and pulses the strobe, then checks that the output code has not moved. It then releases `clr_n` and pulses again. The second pulse must deliver the staged code, which shows the new-data mark survived the ignored strobe. Readback of values that a clear has overwritten is the only port-level view of the input registers, so the clear tests confirm the input-register value through a readback.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int N_CH  = 2;
  localparam int HDR_W = 8;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_WR_IN  = 4'd1,
    OP_UPD    = 4'd2,
    OP_WR_UPD = 4'd3,
    OP_PWR    = 4'd4,
    OP_RDBK   = 4'd9,
    OP_CHAIN  = 4'd15
  } op_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl = s2;
  assign chg = s2 ^ s3;
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int BITS = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sdin,
  input  logic            sync_fall,
  input  logic            sync_rise,
  input  logic            sclk_fall,
  input  logic            sclk_rise,
  output logic            start_o,
  output logic            shift_o,
  output logic            done_o,
  output logic [BITS-1:0] word_o
);
  localparam int CW = $clog2(BITS + 1);

  logic          d1, d2;
  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1 <= 1'b0;
      d2 <= 1'b0;
    end else begin
      d1 <= sdin;
      d2 <= d1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      word_o  <= '0;
      done_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      start_o <= 1'b0;
      if (sync_fall) begin
        active  <= 1'b1;
        cnt     <= '0;
        start_o <= 1'b1;
      end else if (sync_rise) begin
        active <= 1'b0;
        done_o <= active && (cnt == CW'(BITS));
      end else if (active && sclk_fall && cnt != CW'(BITS)) begin
        word_o <= {word_o[BITS-2:0], d2};
        cnt    <= cnt + 1'b1;
      end
    end
  end

  assign shift_o = active && sclk_rise && (cnt != '0);

  a_r3_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(BITS));
  a_r2_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    (sync_rise && cnt != CW'(BITS)) |=> !done_o);
endmodule

// File: rtl/chan_regs.sv
module chan_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_rst,
  input  logic [W-1:0] rst_val,
  input  logic         wr_in,
  input  logic [W-1:0] wr_data,
  input  logic         upd,
  input  logic         ldac_pulse,
  output logic [W-1:0] in_q,
  output logic [W-1:0] dac_q
);
  logic fresh;

  always_ff @(posedge clk) begin
    if (rst || load_rst) begin
      in_q  <= rst_val;
      dac_q <= rst_val;
      fresh <= 1'b0;
    end else begin
      if (wr_in) in_q <= wr_data;
      if (upd) begin
        dac_q <= wr_in ? wr_data : in_q;
        fresh <= 1'b0;
      end else if (ldac_pulse && fresh) begin
        dac_q <= in_q;
        fresh <= wr_in;
      end else if (wr_in) begin
        fresh <= 1'b1;
      end
    end
  end

  a_r8_rst_load: assert property (@(posedge clk) disable iff (rst)
    load_rst |=> (dac_q == $past(rst_val)) && (in_q == $past(rst_val)));
  a_r4_dac_hold: assert property (@(posedge clk) disable iff (rst)
    !(load_rst || upd || ldac_pulse) |=> $stable(dac_q));
endmodule

// File: rtl/dual_dac_serial_regs.sv
module dual_dac_serial_regs
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_sel,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic              sdo_en,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [N_CH-1:0]   pd_state
);
  localparam int FRAME = CODE_W + HDR_W;

  logic [3:0] lvl, chg;
  logic sclk_rise, sclk_fall, sync_rise, sync_fall;
  logic ldac_lvl, ldac_fall, clr_lvl, clr_fall;

  edge_sync #(.W(4), .IDLE(4'b1111)) u_sync (
    .clk(clk), .rst(rst), .din({clr_n, ldac_n, sync_n, sclk}),
    .lvl(lvl), .chg(chg)
  );

  assign sclk_rise = lvl[0] & chg[0];
  assign sclk_fall = ~lvl[0] & chg[0];
  assign sync_rise = lvl[1] & chg[1];
  assign sync_fall = ~lvl[1] & chg[1];
  assign ldac_lvl  = lvl[2];
  assign ldac_fall = ~lvl[2] & chg[2];
  assign clr_lvl   = lvl[3];
  assign clr_fall  = ~lvl[3] & chg[3];

  logic             fr_start, fr_shift, fr_done;
  logic [FRAME-1:0] fr_word;

  frame_rx #(.BITS(FRAME)) u_rx (
    .clk(clk), .rst(rst), .sdin(sdin),
    .sync_fall(sync_fall), .sync_rise(sync_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .start_o(fr_start), .shift_o(fr_shift), .done_o(fr_done), .word_o(fr_word)
  );

  op_e              op;
  logic [3:0]       sel;
  logic [CODE_W-1:0] data;
  logic             valid;
  logic [CODE_W-1:0] rst_val;
  logic             ldac_pulse;

  assign op         = op_e'(fr_word[FRAME-1 -: 4]);
  assign sel        = fr_word[CODE_W +: 4];
  assign data       = fr_word[CODE_W-1:0];
  assign valid      = fr_done && (sel[3:2] == 2'b00);
  assign rst_val    = rst_sel ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  assign ldac_pulse = ldac_fall & clr_lvl;

  logic [CODE_W-1:0] in_regs  [N_CH];
  logic [CODE_W-1:0] dac_regs [N_CH];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic wr_in, upd;
    assign wr_in = valid && sel[ch] && (op == OP_WR_IN || op == OP_WR_UPD);
    assign upd   = valid && sel[ch] &&
                   (op == OP_UPD || op == OP_WR_UPD || (op == OP_WR_IN && !ldac_lvl));
    chan_regs #(.W(CODE_W)) u_chan (
      .clk(clk), .rst(rst), .load_rst(clr_fall), .rst_val(rst_val),
      .wr_in(wr_in), .wr_data(data), .upd(upd), .ldac_pulse(ldac_pulse),
      .in_q(in_regs[ch]), .dac_q(dac_regs[ch])
    );
  end

  assign code_a = dac_regs[0];
  assign code_b = dac_regs[1];

  logic             chain_en, rb_pend, rb_ch, sdo_en_q;
  logic [FRAME-1:0] last_word, out_sr;
  logic [N_CH-1:0]  pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_en  <= 1'b0;
      rb_pend   <= 1'b0;
      rb_ch     <= 1'b0;
      last_word <= '0;
      out_sr    <= '0;
      sdo_en_q  <= 1'b0;
      pd_q      <= '0;
    end else begin
      if (fr_start) begin
        out_sr   <= rb_pend ? {{HDR_W{1'b0}}, in_regs[rb_ch]} : last_word;
        sdo_en_q <= chain_en | rb_pend;
      end else if (fr_shift) begin
        out_sr <= {out_sr[FRAME-2:0], 1'b0};
      end
      if (sync_rise) sdo_en_q <= 1'b0;
      if (fr_done) begin
        last_word <= fr_word;
        rb_pend   <= valid && (op == OP_RDBK);
        if (valid && op == OP_RDBK) rb_ch <= ~sel[0];
        if (valid && op == OP_CHAIN) chain_en <= data[0];
        if (valid && op == OP_PWR) pd_q <= data[N_CH-1:0];
      end
    end
  end

  assign sdo      = out_sr[FRAME-1];
  assign sdo_en   = sdo_en_q;
  assign pd_state = pd_q;

  a_r14_sdo_off: assert property (@(posedge clk) disable iff (rst)
    sync_rise |=> !sdo_en);
  a_r9_clr_freeze: assert property (@(posedge clk) disable iff (rst)
    (!clr_lvl && !clr_fall && !fr_done) |=> ($stable(code_a) && $stable(code_b)));
endmodule

// File: tb/test_dual_dac_serial_regs.sv
module test_dual_dac_serial_regs;
  localparam time HALF = 50ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_sel = 1'b0;
  logic        sclk = 1'b1;
  logic        sync_n = 1'b1;
  logic        sdin = 1'b0;
  logic        ldac_n = 1'b1;
  logic        clr_n = 1'b1;
  logic        sdo, sdo_en;
  logic [15:0] code_a, code_b;
  logic [1:0]  pd_state;

  int n_run = 0;
  int n_fail = 0;

  dual_dac_serial_regs i_dual_dac_serial_regs (
    .clk(clk), .rst(rst), .rst_sel(rst_sel), .sclk(sclk), .sync_n(sync_n),
    .sdin(sdin), .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .sdo_en(sdo_en),
    .code_a(code_a), .code_b(code_b), .pd_state(pd_state)
  );

  always #5ns clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] w, input int nb,
                      output logic [23:0] so, output logic en);
    so = '0;
    en = 1'b0;
    sclk = 1'b1;
    sync_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nb; i++) begin
      sdin = (i < 24) ? w[23-i] : 1'b0;
      #(HALF);
      if (i < 24) so[23-i] = sdo;
      if (i == 0) en = sdo_en;
      sclk = 1'b0;
      #(HALF);
      sclk = 1'b1;
    end
    #(HALF);
    sync_n = 1'b1;
    #(HALF*4);
  endtask

  task automatic send(input logic [23:0] w);
    logic [23:0] so;
    logic en;
    xfer(w, 24, so, en);
  endtask

  task automatic pulse_ldac;
    ldac_n = 1'b0; #100ns; ldac_n = 1'b1; #100ns;
  endtask

  task automatic pulse_clr;
    clr_n = 1'b0; #100ns; clr_n = 1'b1; #100ns;
  endtask

  task automatic do_reset;
    rst = 1'b1; #100ns; rst = 1'b0; #100ns;
  endtask

  task automatic t_por;
    rst_sel = 1'b0;
    do_reset();
    chk("R10 zero A", code_a, 32'h0000);
    chk("R10 zero B", code_b, 32'h0000);
    chk("R14 idle en", sdo_en, 1'b0);
    chk("R10 pd clear", pd_state, 2'b00);
    rst_sel = 1'b1;
    do_reset();
    chk("R10 mid A", code_a, 32'h8000);
    chk("R10 mid B", code_b, 32'h8000);
  endtask

  task automatic t_ldac_async;
    send({4'h1, 4'h1, 16'h1234});
    chk("R4 staged only", code_a, 32'h8000);
    pulse_ldac();
    chk("R4 strobe A", code_a, 32'h1234);
    chk("R4 B untouched", code_b, 32'h8000);
  endtask

  task automatic t_both;
    send({4'h1, 4'h3, 16'hABCD});
    chk("R5 staged A", code_a, 32'h1234);
    pulse_ldac();
    chk("R5 A", code_a, 32'hABCD);
    chk("R5 B", code_b, 32'hABCD);
  endtask

  task automatic t_sync_mode;
    ldac_n = 1'b0;
    #100ns;
    send({4'h1, 4'h2, 16'h5555});
    chk("R6 B now", code_b, 32'h5555);
    chk("R6 A kept", code_a, 32'hABCD);
    ldac_n = 1'b1;
    #100ns;
  endtask

  task automatic t_cmd3;
    send({4'h3, 4'h1, 16'h0F0F});
    chk("R1 write+update A", code_a, 32'h0F0F);
    chk("R1 B kept", code_b, 32'h5555);
  endtask

  task automatic t_cmd2;
    send({4'h1, 4'h2, 16'h7777});
    chk("R7 before", code_b, 32'h5555);
    send({4'h2, 4'h2, 16'h0000});
    chk("R7 after", code_b, 32'h7777);
  endtask

  task automatic t_abort;
    logic [23:0] so;
    logic en;
    xfer({4'h3, 4'h3, 16'hDEAD}, 12, so, en);
    chk("R2 short A", code_a, 32'h0F0F);
    chk("R2 short B", code_b, 32'h7777);
    send({4'h3, 4'b0111, 16'hDEAD});
    chk("R2 reserved A", code_a, 32'h0F0F);
    chk("R2 reserved B", code_b, 32'h7777);
  endtask

  task automatic t_extra;
    logic [23:0] so;
    logic en;
    xfer({4'h3, 4'h1, 16'h2468}, 28, so, en);
    chk("R3 extra edges", code_a, 32'h2468);
  endtask

  task automatic t_readback;
    logic [23:0] so;
    logic en;
    send({4'h9, 4'h2, 16'h0000});
    xfer(24'h000000, 24, so, en);
    chk("R11 read B", so, 32'h007777);
    chk("R11 en", en, 1'b1);
    chk("R14 off after", sdo_en, 1'b0);
    send({4'h9, 4'h1, 16'h0000});
    xfer(24'h000000, 24, so, en);
    chk("R11 read A", so, 32'h002468);
    xfer(24'h000000, 24, so, en);
    chk("R14 not armed", en, 1'b0);
  endtask

  task automatic t_clr;
    logic [23:0] so;
    logic en;
    rst_sel = 1'b0;
    pulse_clr();
    chk("R8 zero A", code_a, 32'h0000);
    chk("R8 zero B", code_b, 32'h0000);
    send({4'h9, 4'h1, 16'h0000});
    xfer(24'h000000, 24, so, en);
    chk("R8 input A zero", so, 32'h000000);
    rst_sel = 1'b1;
    pulse_clr();
    chk("R8 mid A", code_a, 32'h8000);
    chk("R8 mid B", code_b, 32'h8000);
  endtask

  task automatic t_clr_ldac;
    clr_n = 1'b0;
    #100ns;
    send({4'h1, 4'h1, 16'h4321});
    pulse_ldac();
    chk("R9 ignored", code_a, 32'h8000);
    clr_n = 1'b1;
    #100ns;
    chk("R9 still", code_a, 32'h8000);
    pulse_ldac();
    chk("R9 after release", code_a, 32'h4321);
  endtask

  task automatic t_daisy;
    logic [23:0] so;
    logic en;
    send({4'hF, 4'h0, 16'h0001});
    xfer({4'h0, 4'h0, 16'hC3A5}, 24, so, en);
    chk("R12 prior word", so, 32'hF00001);
    chk("R12 en", en, 1'b1);
    xfer(24'h000000, 24, so, en);
    chk("R12 passthrough", so, 32'h00C3A5);
    send({4'hF, 4'h0, 16'h0000});
    xfer(24'h000000, 24, so, en);
    chk("R14 chain off", en, 1'b0);
  endtask

  task automatic t_pd;
    send({4'h4, 4'h0, 16'h0002});
    chk("R13 pd B", pd_state, 2'b10);
    send({4'h4, 4'h0, 16'h0001});
    chk("R13 pd A", pd_state, 2'b01);
    chk("R13 codes kept", code_a, 32'h4321);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2ms;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_por();
    t_ldac_async();
    t_both();
    t_sync_mode();
    t_cmd3();
    t_cmd2();
    t_abort();
    t_extra();
    t_readback();
    t_clr();
    t_clr_ldac();
    t_daisy();
    t_pd();
    finish_run();
  end
endmodule